// File: doc/BRIEF.md
# Host Address Bit-0 Steering Multiplexer

This block sits between the host bus decoder and the video RAM address path of a planar display adapter. For every host access it decides whether the physical address falls inside the memory window that is currently mapped. It also produces the video RAM word address that the access targets. The lowest address bit is the interesting part. In chained (odd/even) operation it is not taken from host A0. Instead it is steered from one of four sources: host A0, host A14, host A16, or the inverse of the page-select bit kept in the miscellaneous output register.

The choice depends on three things:
- whether chaining is on;
- whether the 2-bit window field selects the full 128K window;
- a board strap that tells whether the memory expansion is fitted.

The strap is active-low and pulled high on a minimum-memory board. Software cannot read it. This is why a minimum-memory board and an expanded board react differently to the same register settings. The result is registered and appears one clock after the host request.

Top module: `host_a0_steer`

## Requirements
- R1: With chaining off (bit 1 of `gfx_mode_reg` equal to 0), `vram_addr[0]` equals host A0 for every window and strap setting.
- R2: With chaining on, the expansion fitted (`mem_exp_n` = 0) and a window other than 128K, `vram_addr[0]` is the inverse of `page_sel`.
- R3: With chaining on, the expansion fitted and the 128K window, `vram_addr[0]` equals host A16. Host addresses A0000–AFFFF therefore reach even words and B0000–BFFFF reach odd words.
- R4: With chaining on, the expansion absent and a window other than 128K, `vram_addr[0]` equals host A14.
- R5: With chaining on, the expansion absent and the 128K window, `vram_addr[0]` equals host A0.
- R6: `mem_exp_n` is active-low: 1 means no expansion is fitted and 0 means one is fitted.
- R7: Bits 3:2 of `gfx_mode_reg` select the window. 00 is A0000–BFFFF, 01 is A0000–AFFFF, 10 is B0000–B7FFF and 11 is B8000–BFFFF.
- R8: `vram_req` is 1 only when `host_req` was 1 and `host_addr` lay inside the selected window. Otherwise no access is issued.
- R9: `vram_addr[15:1]` equals bits 15:1 of the host address minus the window base.
- R10: Outputs are registered with one cycle of latency. A synchronous reset clears `vram_req` and `vram_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host memory access request |
| host_addr | input | 20 | Host physical byte address |
| gfx_mode_reg | input | 8 | Graphics mode register value: bit 1 enables chaining, bits 3:2 select the window |
| page_sel | input | 1 | Page-select bit from the miscellaneous output register |
| mem_exp_n | input | 1 | Memory expansion strap, low when fitted |
| vram_req | output | 1 | Registered video RAM access request |
| vram_addr | output | 16 | Registered video RAM word address |

## Verification
The hardest case to reach from the ports is the pair of corner cases where chaining is on and the 128K window is selected. Here the strap alone decides whether bit 0 comes from A16 or passes A0 through. A wrong strap polarity or swapped table entries would stay hidden unless both strap values are driven with addresses whose A0 and A16 differ. The stimulus table therefore holds paired vectors for every strap and window combination. In each pair the candidate source bits disagree: A0 against A14, A16 and the inverted page bit. Every mux entry then produces a value that no other entry would produce.

// File: rtl/hab0_pkg.sv
package hab0_pkg;

    localparam int CHAIN_BIT = 1;
    localparam int MAP_LSB   = 2;

    typedef enum logic [1:0] {
        MAP_128K   = 2'b00,
        MAP_64K_A  = 2'b01,
        MAP_32K_B0 = 2'b10,
        MAP_32K_B8 = 2'b11
    } map_sel_e;

    typedef enum logic [1:0] {
        SRC_HA0  = 2'd0,
        SRC_PAGE = 2'd1,
        SRC_HA16 = 2'd2,
        SRC_HA14 = 2'd3
    } a0_src_e;

    typedef struct packed {
        logic     chain;
        map_sel_e map;
    } gfx_cfg_t;

    function automatic gfx_cfg_t unpack_cfg(input logic [7:0] r);
        gfx_cfg_t c;
        c.chain = r[CHAIN_BIT];
        c.map   = map_sel_e'(r[MAP_LSB +: 2]);
        return c;
    endfunction

    // Window size as log2 of bytes
    function automatic int map_log2(input map_sel_e m);
        case (m)
            MAP_128K:  return 17;
            MAP_64K_A: return 16;
            default:   return 15;
        endcase
    endfunction

    function automatic logic [19:0] map_base(input map_sel_e m);
        case (m)
            MAP_128K:   return 20'hA0000;
            MAP_64K_A:  return 20'hA0000;
            MAP_32K_B0: return 20'hB0000;
            default:    return 20'hB8000;
        endcase
    endfunction

    // Selector index = {chain, map128, expansion_present}
    function automatic a0_src_e route_of(input int idx);
        case (idx)
            4: return SRC_HA14;  // chained, no 128K, minimum memory
            5: return SRC_PAGE;  // chained, no 128K, expanded
            6: return SRC_HA0;   // chained, 128K, minimum memory
            7: return SRC_HA16;  // chained, 128K, expanded
            default: return SRC_HA0; // byte mode
        endcase
    endfunction

endpackage

// File: rtl/hab0_window_dec.sv
module hab0_window_dec
    import hab0_pkg::*;
#(
    parameter int HOST_AW = 20
) (
    input  logic [HOST_AW-1:0] addr,
    input  map_sel_e           map,
    output logic               hit,
    output logic               is_128k,
    output logic [HOST_AW-1:0] offset
);
    localparam logic [HOST_AW-1:0] ONES = '1;

    int                 lg;
    logic [HOST_AW-1:0] base;
    logic [HOST_AW-1:0] mask;

    always_comb begin
        lg      = map_log2(map);
        base    = HOST_AW'(map_base(map));
        mask    = ONES >> (HOST_AW - lg);
        hit     = ((addr & ~mask) == (base & ~mask));
        offset  = addr & mask;
        is_128k = (map == MAP_128K);
    end
endmodule

// File: rtl/hab0_bit0_sel.sv
module hab0_bit0_sel
    import hab0_pkg::*;
#(
    parameter int HOST_AW = 20
) (
    input  logic [HOST_AW-1:0] addr,
    input  logic               page_sel,
    input  logic               chain,
    input  logic               is_128k,
    input  logic               exp_present,
    output logic               a0_out
);
    localparam int NSEL = 8;
    localparam int A14  = 14;
    localparam int A16  = 16;

    logic [3:0]      cand;
    logic [NSEL-1:0] choice;
    logic [2:0]      idx;

    assign cand[SRC_HA0]  = addr[0];
    assign cand[SRC_PAGE] = ~page_sel;
    assign cand[SRC_HA16] = addr[A16];
    assign cand[SRC_HA14] = addr[A14];

    for (genvar i = 0; i < NSEL; i++) begin : g_route
        localparam a0_src_e SRC = route_of(i);
        assign choice[i] = cand[SRC];
    end

    assign idx    = {chain, is_128k, exp_present};
    assign a0_out = choice[idx];
endmodule

// File: rtl/host_a0_steer.sv
module host_a0_steer
    import hab0_pkg::*;
#(
    parameter int HOST_AW = 20,
    parameter int VRAM_AW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [7:0]         gfx_mode_reg,
    input  logic               page_sel,
    input  logic               mem_exp_n,
    output logic               vram_req,
    output logic [VRAM_AW-1:0] vram_addr
);
    gfx_cfg_t           cfg;
    logic               win_hit;
    logic               win_128k;
    logic [HOST_AW-1:0] win_off;
    logic               a0_next;
    logic               unused_bits;

    assign cfg = unpack_cfg(gfx_mode_reg);
    assign unused_bits = ^{gfx_mode_reg[7:4], gfx_mode_reg[0],
                           win_off[HOST_AW-1:VRAM_AW], win_off[0]};

    hab0_window_dec #(.HOST_AW(HOST_AW)) win_i (
        .addr    (host_addr),
        .map     (cfg.map),
        .hit     (win_hit),
        .is_128k (win_128k),
        .offset  (win_off)
    );

    hab0_bit0_sel #(.HOST_AW(HOST_AW)) sel_i (
        .addr        (host_addr),
        .page_sel    (page_sel),
        .chain       (cfg.chain),
        .is_128k     (win_128k),
        .exp_present (~mem_exp_n),
        .a0_out      (a0_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vram_req  <= 1'b0;
            vram_addr <= '0;
        end else begin
            vram_req  <= host_req & win_hit;
            vram_addr <= {win_off[VRAM_AW-1:1], a0_next};
        end
    end

    assert_byte_mode_R1: assert property (@(posedge clk) disable iff (rst)
        (!gfx_mode_reg[1]) |=> (vram_addr[0] == $past(host_addr[0])));

    assert_page_src_R2: assert property (@(posedge clk) disable iff (rst)
        (gfx_mode_reg[1] && !mem_exp_n && gfx_mode_reg[3:2] != 2'b00)
        |=> (vram_addr[0] == !$past(page_sel)));

    assert_a16_src_R3: assert property (@(posedge clk) disable iff (rst)
        (gfx_mode_reg[1] && !mem_exp_n && gfx_mode_reg[3:2] == 2'b00)
        |=> (vram_addr[0] == $past(host_addr[16])));

    assert_a14_src_R4: assert property (@(posedge clk) disable iff (rst)
        (gfx_mode_reg[1] && mem_exp_n && gfx_mode_reg[3:2] != 2'b00)
        |=> (vram_addr[0] == $past(host_addr[14])));

    assert_a0_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (gfx_mode_reg[1] && mem_exp_n && gfx_mode_reg[3:2] == 2'b00)
        |=> (vram_addr[0] == $past(host_addr[0])));

    assert_no_stray_req_R8: assert property (@(posedge clk) disable iff (rst)
        (!host_req || !win_hit) |=> !vram_req);
endmodule

// File: tb/host_a0_steer_tb_top.sv
`timescale 1ns/1ps
module host_a0_steer_tb_top;
    localparam int NV = 18;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_req;
    logic [19:0] host_addr;
    logic [7:0]  gfx_mode_reg;
    logic        page_sel;
    logic        mem_exp_n;
    logic        vram_req;
    logic [15:0] vram_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    host_a0_steer dut_i (
        .clk (clk), .rst (rst), .host_req (host_req), .host_addr (host_addr),
        .gfx_mode_reg (gfx_mode_reg), .page_sel (page_sel), .mem_exp_n (mem_exp_n),
        .vram_req (vram_req), .vram_addr (vram_addr)
    );

    // {req, addr, mode, page, exp_n, exp_req, exp_addr}
    localparam logic [47:0] VEC [NV] = '{
        {1'b1, 20'hA1235, 8'h04, 1'b0, 1'b0, 1'b1, 16'h1235}, // R1
        {1'b1, 20'hA1234, 8'h04, 1'b1, 1'b1, 1'b1, 16'h1234}, // R1
        {1'b1, 20'hA4002, 8'h06, 1'b1, 1'b0, 1'b1, 16'h4002}, // R2
        {1'b1, 20'hA4002, 8'h06, 1'b0, 1'b0, 1'b1, 16'h4003}, // R2
        {1'b1, 20'hA0011, 8'h02, 1'b0, 1'b0, 1'b1, 16'h0010}, // R3 even
        {1'b1, 20'hB0010, 8'h02, 1'b0, 1'b0, 1'b1, 16'h0011}, // R3 odd
        {1'b1, 20'hA4000, 8'h06, 1'b0, 1'b1, 1'b1, 16'h4001}, // R4 R6
        {1'b1, 20'hA0001, 8'h06, 1'b1, 1'b1, 1'b1, 16'h0000}, // R4 R6
        {1'b1, 20'hB0005, 8'h02, 1'b0, 1'b1, 1'b1, 16'h0005}, // R5 R6
        {1'b1, 20'hA0004, 8'h02, 1'b1, 1'b1, 1'b1, 16'h0004}, // R5
        {1'b1, 20'hB4000, 8'h0A, 1'b0, 1'b1, 1'b1, 16'h4001}, // R7 R9
        {1'b1, 20'hB8006, 8'h0E, 1'b1, 1'b0, 1'b1, 16'h0006}, // R7
        {1'b1, 20'hB0000, 8'h06, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
        {1'b1, 20'hB8000, 8'h0A, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
        {1'b1, 20'hC0000, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
        {1'b0, 20'hA0000, 8'h04, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
        {1'b1, 20'hBFFFF, 8'h00, 1'b0, 1'b0, 1'b1, 16'hFFFF}, // R9
        {1'b1, 20'hB0000, 8'h0C, 1'b0, 1'b0, 1'b0, 16'h0000}  // R7
    };
    localparam int TAG [NV] = '{1,1,2,2,3,3,4,4,5,5,7,7,8,8,8,8,9,7};

    task automatic check(input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [47:0] v);
        host_req     = v[47];
        host_addr    = v[46:27];
        gfx_mode_reg = v[26:19];
        page_sel     = v[18];
        mem_exp_n    = v[17];
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(VEC[0]);
        repeat (3) @(negedge clk);
        // R10: reset state while an in-window request is presented
        check("R10", {15'd0, vram_req}, 16'h0000);
        check("R10", vram_addr, 16'h0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d req", TAG[i]), {15'd0, vram_req}, {15'd0, VEC[i][16]});
            if (VEC[i][16])
                check($sformatf("R%0d addr", TAG[i]), vram_addr, VEC[i][15:0]);
        end

        // R10: one-cycle latency; the old result holds until the next edge
        drive(VEC[15]);
        @(negedge clk);
        drive(VEC[6]);
        #1;
        check("R10 latency", {15'd0, vram_req}, 16'h0000);
        @(negedge clk);
        check("R10 latency", vram_addr, 16'h4001);

        // R3 and R5 share the same stimulus; only the strap differs (R6)
        drive({1'b1, 20'hB0000, 8'h02, 1'b0, 1'b0, 17'd0});
        @(negedge clk);
        check("R3 R6 strap low", vram_addr, 16'h0001);
        mem_exp_n = 1'b1;
        @(negedge clk);
        check("R5 R6 strap high", vram_addr, 16'h0000);

        // R10: reset during operation clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid reset", {vram_req, vram_addr[14:0]}, 16'h0000);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule